// File: doc/BRIEF.md
# Fail-First Vector Length Truncation Unit

This unit sits beside a vector loop sequencer and watches the outcome of each element as it completes, in ascending element order. It decides, for the element in front of it, whether that element's result and its condition field may be written back. When a test fails, it cuts the vector length short. It works in one of two modes, chosen for the whole loop.

In the memory-access mode, a fault on any element after the first ends the loop, and the length becomes that element's index. A fault on element 0 is reported as an ordinary trap. In the data-dependent mode, one selected bit of the element's 4-bit condition field is compared with an invert flag. A match is a failure. The truncated length either includes the failing element or excludes it. A compare-only option suppresses every result write and keeps only the condition fields.

A loop begins with a one-cycle start pulse that loads the current length. The truncated length and the stop flag are registered and hold until the next start.

Top module: `ffirst_trunc`

## Requirements
- R1: After reset, `stop_o` is 1, `new_vl_o` is 0, and `res_we_o`, `cr_we_o` and `trap_o` are 0.
- R2: A cycle with `start_i`=1 loads `vl_i`, clamped to MAX_VL, into `new_vl_o` and restarts the expected index at 0. `stop_o` is 0 in the next cycle, unless the loaded length is 0, in which case it is 1. An element presented in the start cycle is ignored.
- R3: In memory mode (`mode_i`=0), an accepted element 0 with `exc_i`=1 raises `trap_o` in the same cycle and is not written. `stop_o` rises in the next cycle and `new_vl_o` is unchanged.
- R4: In memory mode, an accepted element at index k≥1 with `exc_i`=1 is not written. In the next cycle `new_vl_o`=k and `stop_o`=1.
- R5: In data mode (`mode_i`=1), `cr_i` bits [3],[2],[1],[0] are the LT, GT, EQ and SO flags. `sel_i` values 0, 1, 2 and 3 pick LT, GT, EQ and SO respectively. The element fails when the picked bit equals `inv_i`.
- R6: On a data-mode failure at index k with effective inclusive off, `new_vl_o` becomes k and `stop_o` rises in the next cycle. Neither the result nor the condition field of the failing element is written.
- R7: With `vli_i`=1 and `rc_i`=0, a data-mode failure at index k sets `new_vl_o` to k+1. The failing element is written like a passing element.
- R8: When `rc_i`=1, `vli_i` has no effect: a failure at k sets `new_vl_o` to k, and the failing element is not written.
- R9: In data mode with `rc1_i`=1, `res_we_o` is never asserted. The condition field of each written element is still stored.
- R10: `new_vl_o` changes between starts only on an accepted failure, and it never grows. If no element fails, `stop_o` rises in the cycle after the element with index `new_vl_o`-1, and the length is unchanged.
- R11: While `stop_o` is 1, elements produce no writes and leave `new_vl_o` unchanged.
- R12: Traversal is forward only. An element whose index differs from the next expected index (0, 1, 2, … since start) is ignored: no write, no trap, no state change.
- R13: A passing accepted element asserts `res_we_o` unless it is in data mode with `rc1_i`=1. In data mode it asserts `cr_we_o` when `rc_i` or `rc1_i` is 1. `cr_we_o` is always 0 in memory mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a loop, load `vl_i` |
| vl_i | input | VL_W | Vector length at loop start |
| mode_i | input | 1 | 0 memory-access fault mode, 1 data-dependent mode |
| sel_i | input | 2 | Condition bit selector (0 LT, 1 GT, 2 EQ, 3 SO) |
| inv_i | input | 1 | Value of the selected bit that counts as failure |
| vli_i | input | 1 | Include the failing element in the new length |
| rc_i | input | 1 | Record-condition form; disables inclusive length |
| rc1_i | input | 1 | Compare-only: store condition fields, never results |
| elem_valid_i | input | 1 | An element outcome is presented |
| idx_i | input | IDX_W | Index of the presented element |
| exc_i | input | 1 | Presented element would fault (memory mode) |
| cr_i | input | 4 | Condition field of the presented element |
| new_vl_o | output | VL_W | Current, possibly truncated, vector length |
| stop_o | output | 1 | Loop has ended |
| res_we_o | output | 1 | Write the presented element's result |
| cr_we_o | output | 1 | Write the presented element's condition field |
| trap_o | output | 1 | Ordinary fault on element 0 |

## Verification
The assertions watch, on every cycle, the rules that need no history: no writes while stopped, no result writes in compare-only mode, no condition writes in memory mode, a trap only on element 0, and no write of an excluded failing element. They also check that the length never grows and that it changes only after an input that could be a failure. Only the bench scenarios can show the exact truncated value (k against k+1), the clamp on loading, the ignoring of out-of-order indices, and the stop timing after the last element. These depend on the expected index and length carried across many cycles.

// File: rtl/ffirst_pkg.sv
// Shared types for the fail-first truncation unit.
// Assumes: the condition field layout is {LT, GT, EQ, SO} from bit 3 down.
package ffirst_pkg;

    typedef enum logic {
        MODE_MEM  = 1'b0,
        MODE_DATA = 1'b1
    } ff_mode_e;

    typedef enum logic [1:0] {
        PICK_LT = 2'd0,
        PICK_GT = 2'd1,
        PICK_EQ = 2'd2,
        PICK_SO = 2'd3
    } cr_pick_e;

    // Verdict for one presented element.
    typedef struct packed {
        logic fail;      // element ends the loop
        logic keep_len;  // failure that leaves the length as it is
        logic res_we;    // write the result
        logic cr_we;     // write the condition field
        logic trap;      // ordinary fault on element 0
    } ff_verdict_t;

endpackage

// File: rtl/ffirst_cr_test.sv
// Picks one flag from a 4-bit condition field and compares it with the
// invert flag. A match is a failure.
// Assumes: field bits [3:0] = LT, GT, EQ, SO.
module ffirst_cr_test
    import ffirst_pkg::*;
(
    input  logic [3:0] cr_i,
    input  logic [1:0] sel_i,
    input  logic       inv_i,
    output logic       fail_o
);

    logic picked;

    // Select the flag named by the selector.
    always_comb begin
        unique case (cr_pick_e'(sel_i))
            PICK_LT: picked = cr_i[3];
            PICK_GT: picked = cr_i[2];
            PICK_EQ: picked = cr_i[1];
            PICK_SO: picked = cr_i[0];
            default: picked = 1'b0;
        endcase
    end

    // Failure when the picked flag equals the invert flag.
    always_comb fail_o = (picked == inv_i);

endmodule

// File: rtl/ffirst_judge.sv
// Combinational verdict for an accepted element: write enables, trap,
// and the truncated length on failure.
// Assumes: accept_i already covers loop state and index order.
module ffirst_judge
    import ffirst_pkg::*;
#(
    parameter int VL_W  = 7,
    parameter int IDX_W = 6
) (
    input  logic             accept_i,
    input  logic             mode_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             exc_i,
    input  logic             cr_fail_i,
    input  logic             vli_i,
    input  logic             rc_i,
    input  logic             rc1_i,
    output ff_verdict_t      verdict_o,
    output logic [VL_W-1:0]  len_o
);

    logic vli_eff;
    logic cr_on;

    // Inclusive length only counts when the record form is off.
    always_comb vli_eff = vli_i & ~rc_i;
    always_comb cr_on   = rc_i | rc1_i;

    // Build the verdict per mode.
    always_comb begin
        verdict_o = '0;
        len_o     = VL_W'(idx_i);
        if (accept_i) begin
            if (ff_mode_e'(mode_i) == MODE_MEM) begin
                if (exc_i) begin
                    verdict_o.fail     = 1'b1;
                    verdict_o.trap     = (idx_i == '0);
                    verdict_o.keep_len = (idx_i == '0);
                end else begin
                    verdict_o.res_we = 1'b1;
                end
            end else begin
                if (cr_fail_i) begin
                    verdict_o.fail   = 1'b1;
                    verdict_o.res_we = vli_eff & ~rc1_i;
                    verdict_o.cr_we  = vli_eff & cr_on;
                    len_o            = VL_W'(idx_i) + VL_W'(vli_eff);
                end else begin
                    verdict_o.res_we = ~rc1_i;
                    verdict_o.cr_we  = cr_on;
                end
            end
        end
    end

endmodule

// File: rtl/ffirst_track.sv
// Loop state: current length, next expected index and the stop flag.
// Assumes: start has priority over any element in the same cycle.
module ffirst_track
    import ffirst_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int VL_W   = 7,
    parameter int IDX_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [VL_W-1:0]  vl_i,
    input  logic             elem_valid_i,
    input  logic [IDX_W-1:0] idx_i,
    input  ff_verdict_t      verdict_i,
    input  logic [VL_W-1:0]  len_i,
    output logic             accept_o,
    output logic [VL_W-1:0]  cur_vl_o,
    output logic             done_o
);

    localparam logic [VL_W-1:0] VL_CAP = VL_W'(MAX_VL);

    logic [VL_W-1:0] next_idx;
    logic [VL_W-1:0] vl_load;

    // Clamp the loaded length to the supported maximum.
    always_comb vl_load = (vl_i > VL_CAP) ? VL_CAP : vl_i;

    // Accept only the next element in order of a live loop.
    always_comb accept_o = elem_valid_i & ~done_o & ~start_i
                         & (VL_W'(idx_i) == next_idx);

    // Advance the loop, truncate on failure, finish after the last element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_vl_o <= '0;
            next_idx <= '0;
            done_o   <= 1'b1;
        end else if (start_i) begin
            cur_vl_o <= vl_load;
            next_idx <= '0;
            done_o   <= (vl_load == '0);
        end else if (accept_o) begin
            next_idx <= next_idx + 1'b1;
            if (verdict_i.fail) begin
                done_o <= 1'b1;
                if (!verdict_i.keep_len) cur_vl_o <= len_i;
            end else if (next_idx + 1'b1 == cur_vl_o) begin
                done_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ffirst_trunc.sv
// Fail-first vector length truncation unit (top).
// Combines the condition test, the per-element verdict and the loop state.
// Assumes: elements arrive one per cycle at most, in ascending order.
module ffirst_trunc
    import ffirst_pkg::*;
#(
    parameter  int MAX_VL = 64,
    localparam int VL_W   = $clog2(MAX_VL + 1),
    localparam int IDX_W  = $clog2(MAX_VL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [VL_W-1:0]  vl_i,
    input  logic             mode_i,
    input  logic [1:0]       sel_i,
    input  logic             inv_i,
    input  logic             vli_i,
    input  logic             rc_i,
    input  logic             rc1_i,
    input  logic             elem_valid_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             exc_i,
    input  logic [3:0]       cr_i,
    output logic [VL_W-1:0]  new_vl_o,
    output logic             stop_o,
    output logic             res_we_o,
    output logic             cr_we_o,
    output logic             trap_o
);

    logic            cr_fail;
    logic            accept;
    ff_verdict_t     verdict;
    logic [VL_W-1:0] len;

    ffirst_cr_test u_cr_test (
        .cr_i   (cr_i),
        .sel_i  (sel_i),
        .inv_i  (inv_i),
        .fail_o (cr_fail)
    );

    ffirst_judge #(.VL_W(VL_W), .IDX_W(IDX_W)) u_judge (
        .accept_i  (accept),
        .mode_i    (mode_i),
        .idx_i     (idx_i),
        .exc_i     (exc_i),
        .cr_fail_i (cr_fail),
        .vli_i     (vli_i),
        .rc_i      (rc_i),
        .rc1_i     (rc1_i),
        .verdict_o (verdict),
        .len_o     (len)
    );

    ffirst_track #(.MAX_VL(MAX_VL), .VL_W(VL_W), .IDX_W(IDX_W)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .vl_i         (vl_i),
        .elem_valid_i (elem_valid_i),
        .idx_i        (idx_i),
        .verdict_i    (verdict),
        .len_i        (len),
        .accept_o     (accept),
        .cur_vl_o     (new_vl_o),
        .done_o       (stop_o)
    );

    // Drive the per-element write and trap outputs from the verdict.
    always_comb begin
        res_we_o = verdict.res_we;
        cr_we_o  = verdict.cr_we;
        trap_o   = verdict.trap;
    end

endmodule

// File: rtl/ffirst_trunc_chk.sv
// Checker for ffirst_trunc: port-level rules that hold on every cycle.
// Assumes: attached by the bind below; reads top-level ports only.
module ffirst_trunc_chk #(
    parameter int VL_W  = 7,
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             mode_i,
    input logic [1:0]       sel_i,
    input logic             inv_i,
    input logic             vli_i,
    input logic             rc_i,
    input logic             rc1_i,
    input logic             elem_valid_i,
    input logic [IDX_W-1:0] idx_i,
    input logic             exc_i,
    input logic [3:0]       cr_i,
    input logic [VL_W-1:0]  new_vl_o,
    input logic             stop_o,
    input logic             res_we_o,
    input logic             cr_we_o,
    input logic             trap_o
);

    logic maybe_fail;
    // Any input that could count as a failure this cycle.
    always_comb maybe_fail = elem_valid_i & (mode_i ? (cr_i[~sel_i] == inv_i) : exc_i);

    AST_STOP_BLOCKS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> (!res_we_o && !cr_we_o && !trap_o)); // R11

    AST_RC1_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && rc1_i) |-> !res_we_o); // R9

    AST_MEM_NO_CR: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |-> !cr_we_o); // R13

    AST_TRAP_ONLY_ELEM0: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (!mode_i && exc_i && idx_i == '0)); // R3

    AST_TRAP_KEEPS_VL: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> (stop_o && new_vl_o == $past(new_vl_o))); // R3

    AST_EXCL_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && (!vli_i || rc_i) && cr_i[~sel_i] == inv_i) |-> (!res_we_o && !cr_we_o)); // R6

    AST_VL_NEVER_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (new_vl_o <= $past(new_vl_o))); // R10

    AST_TRUNC_NEEDS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !maybe_fail) |=> $stable(new_vl_o)); // R10

endmodule

bind ffirst_trunc ffirst_trunc_chk #(.VL_W(VL_W), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .mode_i       (mode_i),
    .sel_i        (sel_i),
    .inv_i        (inv_i),
    .vli_i        (vli_i),
    .rc_i         (rc_i),
    .rc1_i        (rc1_i),
    .elem_valid_i (elem_valid_i),
    .idx_i        (idx_i),
    .exc_i        (exc_i),
    .cr_i         (cr_i),
    .new_vl_o     (new_vl_o),
    .stop_o       (stop_o),
    .res_we_o     (res_we_o),
    .cr_we_o      (cr_we_o),
    .trap_o       (trap_o)
);

// File: tb/test_ffirst_trunc.sv
// Bench for ffirst_trunc: directed corners plus seeded random loops,
// compared against a behavioural model written from the requirements.
module test_ffirst_trunc;

    localparam int MAX_VL = 64;
    localparam int VL_W   = $clog2(MAX_VL + 1);
    localparam int IDX_W  = $clog2(MAX_VL);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [VL_W-1:0]  vl_i = '0;
    logic             mode_i = 1'b0;
    logic [1:0]       sel_i = '0;
    logic             inv_i = 1'b0, vli_i = 1'b0, rc_i = 1'b0, rc1_i = 1'b0;
    logic             elem_valid_i = 1'b0;
    logic [IDX_W-1:0] idx_i = '0;
    logic             exc_i = 1'b0;
    logic [3:0]       cr_i = '0;
    logic [VL_W-1:0]  new_vl_o;
    logic             stop_o, res_we_o, cr_we_o, trap_o;

    int n_chk = 0;
    int n_bad = 0;
    int m_vl = 0, m_next = 0;
    bit m_done = 1'b1;

    always #4 clk = ~clk;   // 125 MHz

    ffirst_trunc #(.MAX_VL(MAX_VL)) i_ffirst_trunc (.*);

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Registered outputs against the model, sampled at a falling edge.
    task automatic chk_state(input string tag);
        chk(tag, "new_vl", int'(new_vl_o), m_vl);
        chk(tag, "stop", int'(stop_o), int'(m_done));
    endtask

    // Start a loop; called at a falling edge.
    task automatic do_start(input int vl, input bit md, input int sel, input bit inv,
                            input bit vli, input bit rc, input bit rc1, input string tag);
        start_i = 1'b1; vl_i = VL_W'(vl); mode_i = md; sel_i = 2'(sel);
        inv_i = inv; vli_i = vli; rc_i = rc; rc1_i = rc1;
        elem_valid_i = 1'b1; idx_i = '0; exc_i = 1'b1; cr_i = 4'hF;
        #1;
        chk(tag, "res_we in start", int'(res_we_o), 0);
        chk(tag, "cr_we in start", int'(cr_we_o), 0);
        m_vl = (vl > MAX_VL) ? MAX_VL : vl;
        m_next = 0;
        m_done = (m_vl == 0);
        @(negedge clk);
        start_i = 1'b0; elem_valid_i = 1'b0; exc_i = 1'b0;
        chk_state(tag);
    endtask

    // Present one element (or idle); called at a falling edge.
    task automatic step(input bit v, input int idx, input bit e, input logic [3:0] c,
                        input string tag);
        bit acc, pick, fail, vlie, exp_res, exp_cr, exp_trap, keep;
        int len;
        elem_valid_i = v; idx_i = IDX_W'(idx); exc_i = e; cr_i = c;
        #1;
        acc = v && !m_done && (idx == m_next);
        pick = c[3 - int'(sel_i)];
        vlie = vli_i && !rc_i;
        fail = 0; keep = 0; exp_res = 0; exp_cr = 0; exp_trap = 0; len = idx;
        if (acc) begin
            if (!mode_i) begin
                if (e) begin fail = 1; exp_trap = (idx == 0); keep = (idx == 0); end
                else exp_res = 1;
            end else if (pick == inv_i) begin
                fail = 1;
                len = idx + int'(vlie);
                exp_res = vlie && !rc1_i;
                exp_cr = vlie && (rc_i || rc1_i);
            end else begin
                exp_res = !rc1_i;
                exp_cr = rc_i || rc1_i;
            end
        end
        chk(tag, "res_we", int'(res_we_o), int'(exp_res));
        chk(tag, "cr_we", int'(cr_we_o), int'(exp_cr));
        chk(tag, "trap", int'(trap_o), int'(exp_trap));
        if (acc) begin
            m_next++;
            if (fail) begin
                m_done = 1;
                if (!keep) m_vl = len;
            end else if (m_next == m_vl) m_done = 1;
        end
        @(negedge clk);
        elem_valid_i = 1'b0;
        chk_state(tag);
    endtask

    // Feed elements 0..n-1 with one fault or failing field at position f.
    task automatic run_seq(input int n, input int f, input logic [3:0] c_fail,
                           input logic [3:0] c_pass, input string tag);
        for (int k = 0; k < n; k++)
            step(1'b1, k, (k == f), (k == f) ? c_fail : c_pass, tag);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4417));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "stop", int'(stop_o), 1);
        chk("R1", "new_vl", int'(new_vl_o), 0);
        chk("R1", "res_we", int'(res_we_o), 0);
        chk("R1", "trap", int'(trap_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: zero length stops at once; oversize length is clamped
        do_start(0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        do_start(100, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        step(1'b1, 0, 1'b0, 4'h0, "R2");
        // R3: element 0 fault traps and keeps the length
        do_start(5, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        run_seq(2, 0, 4'h0, 4'h0, "R3");
        // R4: later fault truncates to its index
        do_start(8, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        run_seq(6, 3, 4'h0, 4'h0, "R4");
        // R5 R6: EQ (sel 2 -> bit 1) equal to inv=1, exclusive
        do_start(6, 1'b1, 2, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
        run_seq(4, 2, 4'b0010, 4'b1101, "R5");
        // R5: LT (sel 0 -> bit 3) equal to inv=0
        do_start(6, 1'b1, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        run_seq(4, 1, 4'b0111, 4'b1000, "R5");
        // R7: inclusive length
        do_start(6, 1'b1, 2, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
        run_seq(4, 2, 4'b0010, 4'b0000, "R7");
        // R8: inclusive ignored with record form on
        do_start(6, 1'b1, 2, 1'b1, 1'b1, 1'b1, 1'b0, "R8");
        run_seq(4, 2, 4'b0010, 4'b0000, "R8");
        // R9: compare-only stores conditions, no results
        do_start(4, 1'b1, 3, 1'b1, 1'b1, 1'b0, 1'b1, "R9");
        run_seq(4, 2, 4'b0001, 4'b0000, "R9");
        // R10 R13: no failure runs to the end, length intact
        do_start(4, 1'b1, 1, 1'b1, 1'b0, 1'b1, 1'b0, "R10");
        run_seq(4, 9, 4'h0, 4'b1011, "R13");
        // R11: elements after stop are ignored
        step(1'b1, 4, 1'b1, 4'h0, "R11");
        step(1'b1, 0, 1'b1, 4'h0, "R11");
        // R12: out-of-order indices are ignored
        do_start(5, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R12");
        step(1'b1, 2, 1'b1, 4'h0, "R12");
        step(1'b1, 0, 1'b0, 4'h0, "R12");
        step(1'b1, 0, 1'b1, 4'h0, "R12");
        step(1'b1, 1, 1'b0, 4'h0, "R12");

        // Random loops across all modes
        for (int l = 0; l < 300; l++) begin
            do_start(int'($urandom_range(0, 20)), 1'($urandom_range(0, 1)),
                     int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), "R5/R10/R13");
            for (int c = 0; c < 40 && !(m_done && c > 2); c++) begin
                int r;
                int ix;
                r = int'($urandom_range(0, 99));
                ix = (r < 5) ? m_next + 1 : m_next;
                step(r >= 10, ix, $urandom_range(0, 11) == 0,
                     4'($urandom_range(0, 15)), "R5/R10/R13");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule